// File: doc/BRIEF.md
# Dual-Path Latched/Registered Bus Transceiver

This block is one channel group of a bidirectional data transceiver with two independent paths: A-to-B drives the B-side outputs from the A-side inputs, and B-to-A does the reverse. Each path has four controls: latch enable, path clock, active-low clock enable and active-low output enable. With these controls, the path's storage can act in one of three ways. It can pass data through as a transparent latch. It can act as an edge register that loads on a rising edge of the path clock when the clock enable allows it. It can hold its last value.

The whole block runs on one fast system clock. The path clocks are ordinary inputs. All control and data inputs go through a synchronizer of `SYNC_STAGES` flops, so every path sees one consistent snapshot of its inputs. A rising edge of a path clock is recognised when the previous synchronized sample was low and the current one is high. Each tri-state pad is modelled as a data output plus a separate enable.

Reset clears storage and turns off both output enables. Turning on both directions at once is not a legal operating condition. When it happens, the block forces both enables off for as long as the condition lasts and raises a conflict flag that stays set until reset.

Top module: `uni_bus_xcvr`

## Requirements
- R1: With latch enable high, a path is transparent. Its data output equals its data input `SYNC_STAGES` system cycles after the input is applied.
- R2: With latch enable low and clock enable (active low) low, a low-to-high transition of the path clock loads the input data into storage.
- R3: With latch enable low and the path clock steady (high or low), the data output does not change, whatever the data input does.
- R4: With clock enable high, rising edges of the path clock are ignored and the stored value is kept.
- R5: A high output enable (active low) drives the path's enable output low, whatever the other inputs are. The data output still shows the stored or transparent value.
- R6: When latch enable falls, storage keeps the last transparent value. A path clock that is already high at that moment does not count as a capture edge. Only a later low-to-high transition loads new data.
- R7: The B-to-A path behaves like the A-to-B path. Activity on one path leaves the other path's output unchanged.
- R8: During reset and right after it, both enable outputs are low, both data outputs are zero and the conflict flag is low.
- R9: While both output enables are low, both enable outputs are forced low and the conflict flag is set. The flag stays set until reset, and each enable output follows its own control again once the overlap ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | DATA_W | A-side data input |
| b_i | input | DATA_W | B-side data input |
| ab_le_i | input | 1 | A-to-B latch enable (high = transparent) |
| ab_clk_i | input | 1 | A-to-B path clock, sampled |
| ab_cke_ni | input | 1 | A-to-B clock enable, active low |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable (high = transparent) |
| ba_clk_i | input | 1 | B-to-A path clock, sampled |
| ba_cke_ni | input | 1 | B-to-A clock enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| b_o | output | DATA_W | B-side data output |
| b_oe_o | output | 1 | B-side pad enable |
| a_o | output | DATA_W | A-side data output |
| a_oe_o | output | 1 | A-side pad enable |
| conflict_o | output | 1 | Sticky flag: both directions were enabled together |

## Verification
The sharpest corner is closing the latch while the path clock is high. A design that treats the level as an edge would load the new data there, and the bench changes the data at that same moment to catch it. Closing the latch with the clock low, changing the clock and clock enable in the same step, and making an inhibited edge followed by an enabled one all show whether the edge detector follows the clock while the latch is open. A design that mishandles these loads data late or twice. The bench also runs a direction overlap and then releases one side. A flag that is not sticky, or a guard that keeps blocking after the overlap ends, shows up at the ports. It also checks that traffic on one path leaves the other path's held output alone.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic le;
    logic clk;
    logic cke_n;
    logic oe_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  // reset snapshot: latch closed, clock low, clock inhibited, output off
  localparam ctl_t CTL_RST = '{le: 1'b0, clk: 1'b0, cke_n: 1'b1, oe_n: 1'b1};
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
        end else begin
          stg_q[0] <= d_i;
          for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [DATA_W-1:0] d_i,
  output ctl_t              ctl_s_o,
  output logic [DATA_W-1:0] y_o
);
  ctl_t              ctl_s;
  logic [DATA_W-1:0] d_s;
  logic              clk_prev_q;
  logic              rise;
  logic              load;
  logic [DATA_W-1:0] store_q;

  // controls and data share one pipeline depth so each snapshot is coherent
  xcvr_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_i),
    .q_o   (ctl_s)
  );

  xcvr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .q_o   (d_s)
  );

  // previous sample tracks the path clock in every mode, including transparent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= 1'b0;
    else         clk_prev_q <= ctl_s.clk;
  end

  assign rise = ctl_s.clk & ~clk_prev_q;
  assign load = ctl_s.le | (rise & ~ctl_s.cke_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= '0;
    else if (load) store_q <= d_s;
  end

  assign y_o     = ctl_s.le ? d_s : store_q;
  assign ctl_s_o = ctl_s;
endmodule

// File: rtl/xcvr_dir_guard.sv
module xcvr_dir_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ab_oe_ns_i,
  input  logic ba_oe_ns_i,
  output logic ab_oe_o,
  output logic ba_oe_o,
  output logic conflict_o
);
  logic clash;
  logic conflict_q;

  assign clash = ~ab_oe_ns_i & ~ba_oe_ns_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    conflict_q <= 1'b0;
    else if (clash) conflict_q <= 1'b1;
  end

  assign ab_oe_o    = ~ab_oe_ns_i & ~clash;
  assign ba_oe_o    = ~ba_oe_ns_i & ~clash;
  assign conflict_o = conflict_q;
endmodule

// File: rtl/uni_bus_xcvr.sv
module uni_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              ab_le_i,
  input  logic              ab_clk_i,
  input  logic              ab_cke_ni,
  input  logic              ab_oe_ni,
  input  logic              ba_le_i,
  input  logic              ba_clk_i,
  input  logic              ba_cke_ni,
  input  logic              ba_oe_ni,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  output logic              conflict_o
);
  localparam int NPATH = 2;
  localparam int P_AB = 0;
  localparam int P_BA = 1;

  ctl_t              ctl_in  [NPATH];
  ctl_t              ctl_s   [NPATH];
  logic [DATA_W-1:0] din     [NPATH];
  logic [DATA_W-1:0] dout    [NPATH];
  ctl_t              ab_ctl_s;
  ctl_t              ba_ctl_s;

  assign ctl_in[P_AB] = '{le: ab_le_i, clk: ab_clk_i, cke_n: ab_cke_ni, oe_n: ab_oe_ni};
  assign ctl_in[P_BA] = '{le: ba_le_i, clk: ba_clk_i, cke_n: ba_cke_ni, oe_n: ba_oe_ni};
  assign din[P_AB]    = a_i;
  assign din[P_BA]    = b_i;

  generate
    for (genvar p = 0; p < NPATH; p++) begin : g_path
      xcvr_path #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_path (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ctl_i  (ctl_in[p]),
        .d_i    (din[p]),
        .ctl_s_o(ctl_s[p]),
        .y_o    (dout[p])
      );
    end
  endgenerate

  assign ab_ctl_s = ctl_s[P_AB];
  assign ba_ctl_s = ctl_s[P_BA];

  xcvr_dir_guard u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ab_oe_ns_i(ab_ctl_s.oe_n),
    .ba_oe_ns_i(ba_ctl_s.oe_n),
    .ab_oe_o   (b_oe_o),
    .ba_oe_o   (a_oe_o),
    .conflict_o(conflict_o)
  );

  assign b_o = dout[P_AB];
  assign a_o = dout[P_BA];
endmodule

// File: rtl/uni_bus_xcvr_chk.sv
module uni_bus_xcvr_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ab_le_s,
  input logic              ab_clk_s,
  input logic              ab_cke_n_s,
  input logic              ab_oe_n_s,
  input logic              ba_le_s,
  input logic              ba_clk_s,
  input logic              ba_oe_n_s,
  input logic [DATA_W-1:0] b_o,
  input logic [DATA_W-1:0] a_o,
  input logic              b_oe_o,
  input logic              a_oe_o,
  input logic              conflict_o
);
  AST_NO_DUAL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o)); // R9

  AST_ISOLATE_AB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_oe_n_s |-> !b_oe_o); // R5

  AST_ISOLATE_BA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_n_s |-> !a_oe_o); // R5

  AST_CONFLICT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_oe_n_s && !ba_oe_n_s) |=> conflict_o); // R9

  AST_CONFLICT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> conflict_o); // R9

  AST_INHIBIT_HOLD_AB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_s && ab_cke_n_s) |=> (ab_le_s || $stable(b_o))); // R4

  AST_STEADY_HOLD_AB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_s && !(ab_clk_s && !$past(ab_clk_s))) |=> (ab_le_s || $stable(b_o))); // R3

  AST_STEADY_HOLD_BA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_s && !(ba_clk_s && !$past(ba_clk_s))) |=> (ba_le_s || $stable(a_o))); // R7
endmodule

bind uni_bus_xcvr uni_bus_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ab_le_s   (ab_ctl_s.le),
  .ab_clk_s  (ab_ctl_s.clk),
  .ab_cke_n_s(ab_ctl_s.cke_n),
  .ab_oe_n_s (ab_ctl_s.oe_n),
  .ba_le_s   (ba_ctl_s.le),
  .ba_clk_s  (ba_ctl_s.clk),
  .ba_oe_n_s (ba_ctl_s.oe_n),
  .b_o       (b_o),
  .a_o       (a_o),
  .b_oe_o    (b_oe_o),
  .a_oe_o    (a_oe_o),
  .conflict_o(conflict_o)
);

// File: tb/uni_bus_xcvr_bench.sv
module uni_bus_xcvr_bench;
  localparam int W = 18;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 4;
  localparam int NVEC = 17;

  typedef struct packed {
    logic         le;
    logic         clk;
    logic         cke_n;
    logic         oe_n;
    logic [W-1:0] d;
    logic [W-1:0] exp_d;
    logic         exp_oe;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 18'h12345, 18'h12345, 1'b0, 4'd5}, // R5 isolated, transparent
    '{1'b1, 1'b0, 1'b1, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b1, 4'd1}, // R1
    '{1'b1, 1'b0, 1'b1, 1'b0, 18'h15555, 18'h15555, 1'b1, 4'd1}, // R1
    '{1'b1, 1'b1, 1'b1, 1'b0, 18'h15555, 18'h15555, 1'b1, 4'd1}, // R1 clock high while open
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h00F0F, 18'h15555, 1'b1, 4'd6}, // R6 close with clock high
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h00F0F, 18'h15555, 1'b1, 4'd3}, // R3
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h00F0F, 18'h00F0F, 1'b1, 4'd2}, // R2 capture
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h3C3C3, 18'h00F0F, 1'b1, 4'd3}, // R3 steady high
    '{1'b0, 1'b0, 1'b1, 1'b0, 18'h3C3C3, 18'h00F0F, 1'b1, 4'd3}, // R3
    '{1'b0, 1'b1, 1'b1, 1'b0, 18'h3C3C3, 18'h00F0F, 1'b1, 4'd4}, // R4 inhibited edge
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h0A5A5, 18'h00F0F, 1'b1, 4'd3}, // R3 falling edge
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h0A5A5, 18'h0A5A5, 1'b1, 4'd2}, // R2
    '{1'b1, 1'b1, 1'b0, 1'b0, 18'h11111, 18'h11111, 1'b1, 4'd1}, // R1
    '{1'b1, 1'b0, 1'b0, 1'b0, 18'h11111, 18'h11111, 1'b1, 4'd1}, // R1
    '{1'b0, 1'b0, 1'b0, 1'b0, 18'h22222, 18'h11111, 1'b1, 4'd6}, // R6 close with clock low
    '{1'b0, 1'b1, 1'b0, 1'b0, 18'h22222, 18'h22222, 1'b1, 4'd2}, // R2
    '{1'b0, 1'b1, 1'b0, 1'b1, 18'h22222, 18'h22222, 1'b0, 4'd5}  // R5
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_clk = 0, ab_cke_n = 1, ab_oe_n = 1;
  logic ba_le = 0, ba_clk = 0, ba_cke_n = 1, ba_oe_n = 1;
  logic [W-1:0] b_out, a_out;
  logic         b_oe, a_oe, conflict;
  int           n_checks = 0;
  int           n_fail = 0;
  bit           done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uni_bus_xcvr #(.DATA_W(W), .SYNC_STAGES(2)) u_uni_bus_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in),
    .ab_le_i(ab_le), .ab_clk_i(ab_clk), .ab_cke_ni(ab_cke_n), .ab_oe_ni(ab_oe_n),
    .ba_le_i(ba_le), .ba_clk_i(ba_clk), .ba_cke_ni(ba_cke_n), .ba_oe_ni(ba_oe_n),
    .b_o(b_out), .b_oe_o(b_oe), .a_o(a_out), .a_oe_o(a_oe), .conflict_o(conflict)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic idle_all();
    ab_le = 0; ab_clk = 0; ab_cke_n = 1; ab_oe_n = 1;
    ba_le = 0; ba_clk = 0; ba_cke_n = 1; ba_oe_n = 1;
  endtask

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    // R8 state during and after reset
    check("R8", "b_oe in reset", {17'b0, b_oe}, '0);
    rst_n = 1'b1;
    settle();
    check("R8", "b_oe", {17'b0, b_oe}, '0);
    check("R8", "a_oe", {17'b0, a_oe}, '0);
    check("R8", "b_o", b_out, '0);
    check("R8", "a_o", a_out, '0);
    check("R8", "conflict", {17'b0, conflict}, '0);

    // A-to-B walk
    for (int i = 0; i < NVEC; i++) begin
      ab_le = VEC[i].le; ab_clk = VEC[i].clk; ab_cke_n = VEC[i].cke_n; ab_oe_n = VEC[i].oe_n;
      a_in = VEC[i].d;
      settle();
      check($sformatf("R%0d", VEC[i].req), $sformatf("ab step %0d data", i), b_out, VEC[i].exp_d);
      check($sformatf("R%0d", VEC[i].req), $sformatf("ab step %0d oe", i),
            {17'b0, b_oe}, {17'b0, VEC[i].exp_oe});
    end
    idle_all();
    settle();

    // B-to-A walk with inverted data
    for (int i = 0; i < NVEC; i++) begin
      ba_le = VEC[i].le; ba_clk = VEC[i].clk; ba_cke_n = VEC[i].cke_n; ba_oe_n = VEC[i].oe_n;
      b_in = ~VEC[i].d;
      settle();
      check("R7", $sformatf("ba step %0d data", i), a_out, ~VEC[i].exp_d);
      check("R7", $sformatf("ba step %0d oe", i), {17'b0, a_oe}, {17'b0, VEC[i].exp_oe});
    end
    // R7 A-to-B storage untouched by B-to-A traffic
    check("R7", "ab held across ba traffic", b_out, 18'h22222);
    idle_all();
    settle();

    // R9 direction overlap
    ab_oe_n = 0; ba_oe_n = 0;
    settle();
    check("R9", "b_oe forced off", {17'b0, b_oe}, '0);
    check("R9", "a_oe forced off", {17'b0, a_oe}, '0);
    check("R9", "conflict set", {17'b0, conflict}, 18'd1);
    ba_oe_n = 1;
    settle();
    check("R9", "b_oe back on", {17'b0, b_oe}, 18'd1);
    check("R9", "a_oe off", {17'b0, a_oe}, '0);
    check("R9", "conflict sticky", {17'b0, conflict}, 18'd1);

    // R8 mid-run reset clears storage and flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", "b_o after reset", b_out, '0);
    check("R8", "b_oe after reset", {17'b0, b_oe}, '0);
    check("R8", "conflict after reset", {17'b0, conflict}, '0);
    rst_n = 1'b1;
    idle_all();
    settle();

    // R6 edge just after close with clock low, inhibit released same step
    ab_oe_n = 0; ab_le = 1; a_in = 18'h0BEEF;
    settle();
    ab_le = 0; a_in = 18'h01234;
    settle();
    check("R6", "hold after close", b_out, 18'h0BEEF);
    ab_clk = 1; ab_cke_n = 0;
    settle();
    check("R2", "capture with enable in same step", b_out, 18'h01234);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule